// File: doc/BRIEF.md
# Complementary PWM Output Gate with Break Handling

This block sits between the PWM reference generator of a timer and the pads of one or more complementary output pairs. Each pair has a main leg and a complementary leg. For every leg the block decides, each cycle, whether the pad is driven (output enable) and at which level. A single registered master-enable flag controls all pairs. Software sets and clears this flag. An update event can also set it automatically. A qualified break input clears it.

While the master enable is set, a leg whose own enable bit is on passes its PWM reference level straight through. A leg whose own enable bit is off follows the run off-state selection. It either releases the pad, or holds it driven at the inactive level (0) provided the other leg of its pair is enabled. While the master enable is clear, the idle off-state selection decides between releasing both legs and driving each leg at its programmed idle level. In the driven case the pair needs at least one of its enables set.

The break is qualified combinationally from its enable, polarity and disarm controls. It is sampled on the clock edge. The pad controls are combinational from the registered master enable, so a break reaches the pads one clock edge after it is sampled. There is no further latency. All pins are plain level controls. No data stream crosses this block, so there is no valid/ready handshake.

Top module: `pwm_brk_oectl`

## Requirements
- R1: After reset the master enable (`main_en`) reads 0.
- R2: A break counts as active when `brk_en`=1, `brk_disarm`=0 and `brk_in` equals `brk_pol` (0 means active low, 1 means active high). An active break at a clock edge makes `main_en` 0 after that edge. This overrides any software set or update event in the same cycle.
- R3: With no active break (either `brk_en`=0 or `brk_disarm`=1, whatever `brk_in` is), and with no set, clear or qualifying update event, `main_en` keeps its value across the edge.
- R4: With no active break, `sw_clr`=1 makes `main_en` 0 after the edge. Otherwise `sw_set`=1 makes it 1. Clear wins over set.
- R5: With no active break and no `sw_clr`, an `upd_evt` pulse sets `main_en` only when `auto_en`=1. With `auto_en`=0 the update event has no effect.
- R6: With `main_en`=1 and a leg's own enable at 1, that leg has output enable 1 and its level equals its PWM reference.
- R7: With `main_en`=1 and a leg's own enable at 0, the leg's behaviour depends on `offsel_run` and on its partner. If `offsel_run`=1 and the partner leg's enable is 1, the leg is driven with output enable 1 at level 0. Otherwise its output enable is 0.
- R8: With `main_en`=0 and `offsel_idle`=1, each leg of a pair with at least one leg enable at 1 has output enable 1 and drives its idle bit. A pair with both enables at 0 has both output enables at 0.
- R9: With `main_en`=0 and `offsel_idle`=0, every output enable is 0.
- R10: Output levels and enables follow changes of the reference, enable, idle and off-state inputs in the same cycle, with no clock in between.
- R11: A leg whose output enable is 0 presents level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_main | input | NPAIR | PWM reference level, main legs |
| ref_comp | input | NPAIR | PWM reference level, complementary legs |
| en_main | input | NPAIR | Leg enable, main legs |
| en_comp | input | NPAIR | Leg enable, complementary legs |
| idle_main | input | NPAIR | Idle level, main legs |
| idle_comp | input | NPAIR | Idle level, complementary legs |
| offsel_run | input | 1 | Run off-state: 1 drives an unused leg at 0, 0 releases it |
| offsel_idle | input | 1 | Idle off-state: 1 drives idle levels, 0 releases all legs |
| brk_en | input | 1 | Break enable |
| brk_pol | input | 1 | Break active level |
| brk_disarm | input | 1 | 1 disarms the break input |
| brk_in | input | 1 | Filtered break input |
| auto_en | input | 1 | Allow update event to set the master enable |
| upd_evt | input | 1 | Update-event strobe |
| sw_set | input | 1 | Software set of the master enable |
| sw_clr | input | 1 | Software clear of the master enable |
| main_en | output | 1 | Registered master enable |
| lvl_main | output | NPAIR | Pad level, main legs |
| lvl_comp | output | NPAIR | Pad level, complementary legs |
| oe_main | output | NPAIR | Pad output enable, main legs |
| oe_comp | output | NPAIR | Pad output enable, complementary legs |

## Verification
The hardest case to reach from the ports is a cycle where several requests arrive together: an active break lands in the same cycle as a software set and a qualifying update event, or a disarmed break sits at its active level while the master enable must hold. Random stimulus makes software set and update events frequent, so the master enable spends long stretches at 1. It also raises break enable only part of the time, with random polarity and disarm, so breaks both strike a set flag and are ignored while it is set. Directed steps then force the exact coincidences. Another directed step toggles references and enables between clock edges to show the pads follow them without a clock.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;

  localparam int LEGS_PER_PAIR = 2;
  localparam int LEG_MAIN = 0;
  localparam int LEG_COMP = 1;

  typedef enum logic [1:0] {
    LEG_RELEASED = 2'd0,
    LEG_PARKED   = 2'd1,
    LEG_IDLING   = 2'd2,
    LEG_RUNNING  = 2'd3
  } leg_mode_e;

  typedef struct packed {
    logic lvl;
    logic oe;
  } leg_drv_t;

  function automatic leg_drv_t drv_of_mode(leg_mode_e m, logic ref_lvl, logic idle_lvl);
    leg_drv_t d;
    case (m)
      LEG_RUNNING: begin d.oe = 1'b1; d.lvl = ref_lvl;  end
      LEG_IDLING:  begin d.oe = 1'b1; d.lvl = idle_lvl; end
      LEG_PARKED:  begin d.oe = 1'b1; d.lvl = 1'b0;     end
      default:     begin d.oe = 1'b0; d.lvl = 1'b0;     end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwm_brk_qual.sv
module pwm_brk_qual (
  input  logic brk_en,
  input  logic brk_pol,
  input  logic brk_disarm,
  input  logic brk_in,
  output logic brk_act
);
  logic level_hit;

  always_comb begin
    level_hit = (brk_in == brk_pol);
    brk_act   = brk_en & ~brk_disarm & level_hit;
  end
endmodule

// File: rtl/pwm_brk_menable.sv
module pwm_brk_menable (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_act,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic auto_en,
  input  logic upd_evt,
  output logic main_en
);
  logic me_q;
  logic me_d;
  logic auto_hit;

  always_comb begin
    auto_hit = auto_en & upd_evt;
    me_d     = me_q;
    if (brk_act)               me_d = 1'b0;
    else if (sw_clr)           me_d = 1'b0;
    else if (sw_set | auto_hit) me_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) me_q <= 1'b0;
    else        me_q <= me_d;
  end

  assign main_en = me_q;
endmodule

// File: rtl/pwm_brk_pairdrv.sv
module pwm_brk_pairdrv
  import pwm_brk_pkg::*;
(
  input  logic                     main_en,
  input  logic                     offsel_run,
  input  logic                     offsel_idle,
  input  logic [LEGS_PER_PAIR-1:0] ref_lvl,
  input  logic [LEGS_PER_PAIR-1:0] leg_en,
  input  logic [LEGS_PER_PAIR-1:0] idle_lvl,
  output logic [LEGS_PER_PAIR-1:0] pad_lvl,
  output logic [LEGS_PER_PAIR-1:0] pad_oe
);
  logic pair_any;
  assign pair_any = |leg_en;

  for (genvar k = 0; k < LEGS_PER_PAIR; k++) begin : g_leg
    leg_mode_e mode;
    leg_drv_t  drv;

    always_comb begin
      if (main_en) begin
        if (leg_en[k])                    mode = LEG_RUNNING;
        else if (offsel_run && pair_any)  mode = LEG_PARKED;
        else                              mode = LEG_RELEASED;
      end else begin
        if (offsel_idle && pair_any)      mode = LEG_IDLING;
        else                              mode = LEG_RELEASED;
      end
      drv = drv_of_mode(mode, ref_lvl[k], idle_lvl[k]);
    end

    assign pad_lvl[k] = drv.lvl;
    assign pad_oe[k]  = drv.oe;
  end
endmodule

// File: rtl/pwm_brk_oectl.sv
module pwm_brk_oectl
  import pwm_brk_pkg::*;
#(
  parameter int NPAIR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] ref_main,
  input  logic [NPAIR-1:0] ref_comp,
  input  logic [NPAIR-1:0] en_main,
  input  logic [NPAIR-1:0] en_comp,
  input  logic [NPAIR-1:0] idle_main,
  input  logic [NPAIR-1:0] idle_comp,
  input  logic             offsel_run,
  input  logic             offsel_idle,
  input  logic             brk_en,
  input  logic             brk_pol,
  input  logic             brk_disarm,
  input  logic             brk_in,
  input  logic             auto_en,
  input  logic             upd_evt,
  input  logic             sw_set,
  input  logic             sw_clr,
  output logic             main_en,
  output logic [NPAIR-1:0] lvl_main,
  output logic [NPAIR-1:0] lvl_comp,
  output logic [NPAIR-1:0] oe_main,
  output logic [NPAIR-1:0] oe_comp
);
  logic brk_act;

  pwm_brk_qual u_qual (
    .brk_en     (brk_en),
    .brk_pol    (brk_pol),
    .brk_disarm (brk_disarm),
    .brk_in     (brk_in),
    .brk_act    (brk_act)
  );

  pwm_brk_menable u_men (
    .clk     (clk),
    .rst_n   (rst_n),
    .brk_act (brk_act),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .auto_en (auto_en),
    .upd_evt (upd_evt),
    .main_en (main_en)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [LEGS_PER_PAIR-1:0] pl;
    logic [LEGS_PER_PAIR-1:0] po;

    pwm_brk_pairdrv u_drv (
      .main_en     (main_en),
      .offsel_run  (offsel_run),
      .offsel_idle (offsel_idle),
      .ref_lvl     ({ref_comp[p],  ref_main[p]}),
      .leg_en      ({en_comp[p],   en_main[p]}),
      .idle_lvl    ({idle_comp[p], idle_main[p]}),
      .pad_lvl     (pl),
      .pad_oe      (po)
    );

    assign lvl_main[p] = pl[LEG_MAIN];
    assign lvl_comp[p] = pl[LEG_COMP];
    assign oe_main[p]  = po[LEG_MAIN];
    assign oe_comp[p]  = po[LEG_COMP];
  end
endmodule

// File: rtl/pwm_brk_oectl_chk.sv
module pwm_brk_oectl_chk #(
  parameter int NPAIR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPAIR-1:0] ref_main,
  input logic [NPAIR-1:0] en_main,
  input logic [NPAIR-1:0] en_comp,
  input logic             offsel_idle,
  input logic             brk_en,
  input logic             brk_pol,
  input logic             brk_disarm,
  input logic             brk_in,
  input logic             auto_en,
  input logic             upd_evt,
  input logic             sw_set,
  input logic             sw_clr,
  input logic             main_en,
  input logic [NPAIR-1:0] lvl_main,
  input logic [NPAIR-1:0] lvl_comp,
  input logic [NPAIR-1:0] oe_main,
  input logic [NPAIR-1:0] oe_comp
);
  logic hit;
  assign hit = brk_en && !brk_disarm && (brk_in == brk_pol);

  assert_break_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !main_en);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !sw_set && !sw_clr && !(auto_en && upd_evt)) |=> $stable(main_en));

  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !main_en);

  assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !sw_clr && !hit) |=> main_en);

  assert_auto_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && upd_evt && !sw_clr && !hit) |=> main_en);

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en && !offsel_idle) |-> (oe_main == '0 && oe_comp == '0));

  assert_released_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_main & ~oe_main) == '0) && ((lvl_comp & ~oe_comp) == '0));

  for (genvar p = 0; p < NPAIR; p++) begin : g_p
    assert_run_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (main_en && en_main[p]) |-> (oe_main[p] && lvl_main[p] == ref_main[p]));
  end
endmodule

bind pwm_brk_oectl pwm_brk_oectl_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_main(ref_main), .en_main(en_main),
  .en_comp(en_comp), .offsel_idle(offsel_idle), .brk_en(brk_en),
  .brk_pol(brk_pol), .brk_disarm(brk_disarm), .brk_in(brk_in),
  .auto_en(auto_en), .upd_evt(upd_evt), .sw_set(sw_set), .sw_clr(sw_clr),
  .main_en(main_en), .lvl_main(lvl_main), .lvl_comp(lvl_comp),
  .oe_main(oe_main), .oe_comp(oe_comp)
);

// File: tb/pwm_brk_oectl_tb.sv
module pwm_brk_oectl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] ref_main = '0, ref_comp = '0, en_main = '0, en_comp = '0;
  logic [NP-1:0] idle_main = '0, idle_comp = '0;
  logic offsel_run = 0, offsel_idle = 0, brk_en = 0, brk_pol = 0, brk_disarm = 0;
  logic brk_in = 0, auto_en = 0, upd_evt = 0, sw_set = 0, sw_clr = 0;
  logic main_en;
  logic [NP-1:0] lvl_main, lvl_comp, oe_main, oe_comp;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_me = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_brk_oectl #(.NPAIR(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_main(ref_main), .ref_comp(ref_comp),
    .en_main(en_main), .en_comp(en_comp), .idle_main(idle_main),
    .idle_comp(idle_comp), .offsel_run(offsel_run), .offsel_idle(offsel_idle),
    .brk_en(brk_en), .brk_pol(brk_pol), .brk_disarm(brk_disarm),
    .brk_in(brk_in), .auto_en(auto_en), .upd_evt(upd_evt), .sw_set(sw_set),
    .sw_clr(sw_clr), .main_en(main_en), .lvl_main(lvl_main),
    .lvl_comp(lvl_comp), .oe_main(oe_main), .oe_comp(oe_comp)
  );

  function automatic logic brk_hot();
    return brk_en && !brk_disarm && (brk_in == brk_pol);
  endfunction

  function automatic logic me_next(logic cur);
    if (brk_hot()) return 1'b0;
    if (sw_clr) return 1'b0;
    if (sw_set) return 1'b1;
    if (auto_en && upd_evt) return 1'b1;
    return cur;
  endfunction

  function automatic string me_tag();
    if (brk_hot()) return "R2";
    if (sw_clr || sw_set) return "R4";
    if (upd_evt) return "R5";
    return "R3";
  endfunction

  // expected {oe,lvl} for a leg: own enable, partner enable, reference, idle bit
  function automatic logic [1:0] leg_exp(logic me, logic own, logic other, logic r, logic idl);
    if (me) begin
      if (own) return {1'b1, r};
      if (offsel_run && other) return 2'b10;
      return 2'b00;
    end
    if (offsel_idle && (own || other)) return {1'b1, idl};
    return 2'b00;
  endfunction

  function automatic string leg_tag(logic me, logic own);
    if (me) return own ? "R6" : "R7";
    return offsel_idle ? "R8" : "R9";
  endfunction

  task automatic cmp(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic check_outputs(string extra);
    cmp({me_tag_prev, extra}, {1'b0, main_en}, {1'b0, exp_me});
    for (int p = 0; p < NP; p++) begin
      cmp({leg_tag(exp_me, en_main[p]), extra}, {oe_main[p], lvl_main[p]},
          leg_exp(exp_me, en_main[p], en_comp[p], ref_main[p], idle_main[p]));
      cmp({leg_tag(exp_me, en_comp[p]), extra}, {oe_comp[p], lvl_comp[p]},
          leg_exp(exp_me, en_comp[p], en_main[p], ref_comp[p], idle_comp[p]));
      n_chk++;
      if ((!oe_main[p] && lvl_main[p]) || (!oe_comp[p] && lvl_comp[p])) begin
        n_bad++;
        $display("FAIL R11 pair %0d: actual oe %b%b lvl %b%b expected lvl 0 when released",
                 p, oe_main[p], oe_comp[p], lvl_main[p], lvl_comp[p]);
      end
    end
  endtask

  string me_tag_prev = "R1";

  // inputs are stable here; advance the model across the next rising edge
  task automatic clock_model();
    string t;
    logic nx;
    t  = me_tag();
    nx = me_next(exp_me);
    @(posedge clk);
    exp_me = nx;
    me_tag_prev = t;
    @(negedge clk);
  endtask

  task automatic randomize_inputs();
    ref_main = NP'($urandom); ref_comp = NP'($urandom);
    en_main = NP'($urandom);  en_comp = NP'($urandom);
    idle_main = NP'($urandom); idle_comp = NP'($urandom);
    offsel_run = 1'($urandom); offsel_idle = 1'($urandom);
    brk_en = ($urandom % 4) == 0;
    brk_pol = 1'($urandom); brk_disarm = 1'($urandom); brk_in = 1'($urandom);
    auto_en = 1'($urandom); upd_evt = ($urandom % 4) == 0;
    sw_set = ($urandom % 4) == 0; sw_clr = ($urandom % 10) == 0;
  endtask

  task automatic quiet();
    brk_en = 0; sw_set = 0; sw_clr = 0; upd_evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    repeat (3) @(negedge clk);
    // R1: reset state, idle release
    #1 check_outputs("");
    rst_n = 1'b1;

    // R4 set then R10: pads follow inputs between edges
    sw_set = 1; clock_model(); quiet();
    en_main = 2'b11; en_comp = 2'b00; offsel_run = 1; ref_main = 2'b01;
    #1 check_outputs("");
    ref_main = 2'b10; en_comp = 2'b01;
    #1 check_outputs("/R10");
    offsel_run = 0;
    #1 check_outputs("/R10");

    // R3: disarmed break at active level is ignored
    brk_en = 1; brk_pol = 1; brk_in = 1; brk_disarm = 1; clock_model();
    #1 check_outputs("");
    // R3: break enable off
    brk_en = 0; clock_model();
    #1 check_outputs("");
    // R2: active-low break beats set and update in same cycle
    brk_en = 1; brk_disarm = 0; brk_pol = 0; brk_in = 0;
    sw_set = 1; auto_en = 1; upd_evt = 1; clock_model();
    #1 check_outputs("");
    // R5: break still there, update ignored; then released
    sw_set = 0; clock_model();
    #1 check_outputs("");
    brk_in = 1; clock_model();
    #1 check_outputs("");
    // R5: auto disabled, update has no effect
    sw_clr = 1; upd_evt = 0; clock_model();
    auto_en = 0; sw_clr = 0; upd_evt = 1; clock_model();
    #1 check_outputs("");
    // R4: clear wins over set
    upd_evt = 0; sw_set = 1; clock_model(); sw_clr = 1; clock_model();
    #1 check_outputs("");
    // R8: idle drive with one enable
    quiet(); offsel_idle = 1; idle_main = 2'b10; idle_comp = 2'b01;
    en_main = 2'b01; en_comp = 2'b00;
    #1 check_outputs("");

    for (int i = 0; i < N_RAND; i++) begin
      randomize_inputs();
      #1 check_outputs("");
      clock_model();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule